// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block produces the control-store address for a microcoded controller, one address per clock. It keeps a 7-bit control address register that drives a 128-word control store, and a single return-address register for one level of microcode subroutine. Each cycle it reads the sequencing fields of the microinstruction that was just fetched: a condition selector, a branch kind and a 7-bit target. It also reads three processor status bits and the 4-bit opcode of the machine instruction. From these it picks the next address.

The control address register is the block's state. Its transitions are named as follows:
- **STEP**: load the current address plus one.
- **JUMP**: load the target field.
- **ENTER**: load the target field and save the address plus one as the return address.
- **LEAVE**: load the saved return address.
- **DISPATCH**: load the opcode-derived routine start.

Which transition is taken is decided by combinational logic from the branch kind and the tested condition.

The surrounding controller uses the sequencing fields of a 20-bit microinstruction. From the most significant bit down, that word holds three 3-bit micro-operation fields, a 2-bit condition selector, a 2-bit branch kind and a 7-bit target. This block receives only the last three fields. Micro-operation decoding stays outside.

Top module: `useq_next_addr`

## Requirements
- R1: A synchronous reset sets the address register to 64 and clears the return register, so a return taken right after reset goes to address 0.
- R2: The condition selector picks the tested bit: 00 gives constant 1, 01 gives `ind_bit`, 10 gives `acc_sign`, 11 gives `acc_is_zero`.
- R3: With branch kind 00 (jump), a true condition loads the target into the address register and a false condition loads the address plus one.
- R4: With branch kind 01 (call), a true condition loads the target and stores the address plus one in the return register. A false condition loads the address plus one and leaves the return register unchanged.
- R5: With branch kind 10 (return), the address register loads the return register whatever the condition is.
- R6: With branch kind 11 (dispatch), the address register loads a 0 bit, then `opcode[3:0]`, then two 0 bits, for any condition. The 16 opcodes therefore land at 0, 4, …, 60.
- R7: The address plus one wraps from 127 to 0, both when it steps the address register and when it is saved by a call.
- R8: The return register holds one address only, so a taken call inside a called routine replaces the earlier return address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cond_sel | input | 2 | Condition selector field of the current microinstruction |
| br_kind | input | 2 | Branch kind field of the current microinstruction |
| br_target | input | 7 | Target address field of the current microinstruction |
| ind_bit | input | 1 | Indirect-address status bit of the data register |
| acc_sign | input | 1 | Sign bit of the accumulator |
| acc_is_zero | input | 1 | Accumulator-equals-zero flag |
| opcode | input | 4 | Machine instruction opcode used by dispatch |
| car_o | output | 7 | Current control-store address |

## Verification
A taken call performs two actions on the same clock edge. It loads the address register from the target, and it writes the return register from the old address plus one. A return issued on the very next cycle then reads that freshly written value. The bench provokes this with back-to-back call and return vectors, and with a call placed at address 127. It judges the result by whether the return lands on the address after the call, and on 0 for the call at 127. Random vectors mix all branch kinds and status bits so that calls, returns and wraps also meet in arbitrary order. Each result is compared with a bench model of the address and return registers.

// File: rtl/useq_pkg.sv
package useq_pkg;
    typedef enum logic [1:0] {
        BR_JUMP  = 2'b00,
        BR_CALL  = 2'b01,
        BR_RET   = 2'b10,
        BR_DISP  = 2'b11
    } br_kind_e;

    typedef enum logic [1:0] {
        CS_ONE   = 2'b00,
        CS_IND   = 2'b01,
        CS_SIGN  = 2'b10,
        CS_ZERO  = 2'b11
    } cond_sel_e;

    typedef enum logic [1:0] {
        SRC_STEP   = 2'b00,
        SRC_LEAVE  = 2'b01,
        SRC_TARGET = 2'b10,
        SRC_DISP   = 2'b11
    } addr_src_e;
endpackage

// File: rtl/useq_cond_mux.sv
module useq_cond_mux
    import useq_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       ind_bit,
    input  logic       acc_sign,
    input  logic       acc_is_zero,
    output logic       cond
);
    always_comb begin
        unique case (cond_sel_e'(sel))
            CS_ONE:  cond = 1'b1;
            CS_IND:  cond = ind_bit;
            CS_SIGN: cond = acc_sign;
            CS_ZERO: cond = acc_is_zero;
            default: cond = 1'b1;
        endcase
    end
endmodule

// File: rtl/useq_src_ctrl.sv
module useq_src_ctrl
    import useq_pkg::*;
(
    input  logic [1:0] br_kind,
    input  logic       cond,
    output addr_src_e  src,
    output logic       save_ret
);
    always_comb begin
        src      = SRC_STEP;
        save_ret = 1'b0;
        unique case (br_kind_e'(br_kind))
            BR_JUMP: src = cond ? SRC_TARGET : SRC_STEP;
            BR_CALL: begin
                src      = cond ? SRC_TARGET : SRC_STEP;
                save_ret = cond;
            end
            BR_RET:  src = SRC_LEAVE;
            BR_DISP: src = SRC_DISP;
            default: src = SRC_STEP;
        endcase
    end
endmodule

// File: rtl/useq_addr_mux.sv
module useq_addr_mux
    import useq_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int OP_W      = 4,
    parameter int MAP_SHIFT = 2
) (
    input  addr_src_e         src,
    input  logic [ADDR_W-1:0] step_addr,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic [ADDR_W-1:0] target,
    input  logic [OP_W-1:0]   opcode,
    output logic [ADDR_W-1:0] next_addr
);
    localparam int PAD_HI = ADDR_W - OP_W - MAP_SHIFT;

    logic [ADDR_W-1:0] disp_addr;

    generate
        if (PAD_HI > 0) begin : g_pad
            assign disp_addr = {{PAD_HI{1'b0}}, opcode, {MAP_SHIFT{1'b0}}};
        end else begin : g_nopad
            assign disp_addr = {opcode, {MAP_SHIFT{1'b0}}};
        end
    endgenerate

    always_comb begin
        unique case (src)
            SRC_STEP:   next_addr = step_addr;
            SRC_LEAVE:  next_addr = ret_addr;
            SRC_TARGET: next_addr = target;
            SRC_DISP:   next_addr = disp_addr;
            default:    next_addr = step_addr;
        endcase
    end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
    import useq_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int OP_W       = 4,
    parameter int MAP_SHIFT  = 2,
    parameter int RESET_ADDR = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cond_sel,
    input  logic [1:0]        br_kind,
    input  logic [ADDR_W-1:0] br_target,
    input  logic              ind_bit,
    input  logic              acc_sign,
    input  logic              acc_is_zero,
    input  logic [OP_W-1:0]   opcode,
    output logic [ADDR_W-1:0] car_o
);
    localparam logic [ADDR_W-1:0] CAR_INIT = ADDR_W'(RESET_ADDR);

    logic [ADDR_W-1:0] car_q;
    logic [ADDR_W-1:0] sbr_q;
    logic [ADDR_W-1:0] step_addr;
    logic [ADDR_W-1:0] next_addr;
    logic              cond;
    logic              save_ret;
    addr_src_e         src;

    assign step_addr = car_q + 1'b1;

    useq_cond_mux cond_i (
        .sel         (cond_sel),
        .ind_bit     (ind_bit),
        .acc_sign    (acc_sign),
        .acc_is_zero (acc_is_zero),
        .cond        (cond)
    );

    useq_src_ctrl ctrl_i (
        .br_kind  (br_kind),
        .cond     (cond),
        .src      (src),
        .save_ret (save_ret)
    );

    useq_addr_mux #(
        .ADDR_W    (ADDR_W),
        .OP_W      (OP_W),
        .MAP_SHIFT (MAP_SHIFT)
    ) mux_i (
        .src       (src),
        .step_addr (step_addr),
        .ret_addr  (sbr_q),
        .target    (br_target),
        .opcode    (opcode),
        .next_addr (next_addr)
    );

    // State register: control address and single return slot
    always_ff @(posedge clk) begin
        if (rst) begin
            car_q <= CAR_INIT;
            sbr_q <= '0;
        end else begin
            car_q <= next_addr;
            if (save_ret) begin
                sbr_q <= step_addr;
            end
        end
    end

    // Output process
    always_comb begin
        car_o = car_q;
    end
endmodule

// File: rtl/useq_next_addr_chk.sv
module useq_next_addr_chk #(
    parameter int ADDR_W     = 7,
    parameter int OP_W       = 4,
    parameter int MAP_SHIFT  = 2,
    parameter int RESET_ADDR = 64
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        cond_sel,
    input logic [1:0]        br_kind,
    input logic [ADDR_W-1:0] br_target,
    input logic              ind_bit,
    input logic              acc_sign,
    input logic              acc_is_zero,
    input logic [OP_W-1:0]   opcode,
    input logic [ADDR_W-1:0] car,
    input logic [ADDR_W-1:0] sbr
);
    logic rst_seen = 1'b0;
    logic tested;

    always_comb begin
        case (cond_sel)
            2'b00:   tested = 1'b1;
            2'b01:   tested = ind_bit;
            2'b10:   tested = acc_sign;
            default: tested = acc_is_zero;
        endcase
    end

    always_ff @(posedge clk) begin
        rst_seen <= rst;
    end

    // R1: one edge after reset, the registers hold their initial values
    always @(posedge clk) begin
        if (rst_seen) begin
            assert_reset_state_R1: assert (car == ADDR_W'(RESET_ADDR) && sbr == '0);
        end
    end

    assert_jump_taken_R3: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b00 && tested) |=> car == $past(br_target));

    assert_jump_fall_R7: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b00 && !tested) |=> car == $past(car) + 1'b1);

    assert_call_save_R8: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b01 && tested) |=> (car == $past(br_target) && sbr == $past(car) + 1'b1));

    assert_call_skip_R4: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b01 && !tested) |=> (car == $past(car) + 1'b1 && $stable(sbr)));

    assert_return_R5: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b10) |=> car == $past(sbr));

    assert_dispatch_R6: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b11) |=> car == ADDR_W'({$past(opcode), {MAP_SHIFT{1'b0}}}));
endmodule

bind useq_next_addr useq_next_addr_chk #(
    .ADDR_W     (ADDR_W),
    .OP_W       (OP_W),
    .MAP_SHIFT  (MAP_SHIFT),
    .RESET_ADDR (RESET_ADDR)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .cond_sel    (cond_sel),
    .br_kind     (br_kind),
    .br_target   (br_target),
    .ind_bit     (ind_bit),
    .acc_sign    (acc_sign),
    .acc_is_zero (acc_is_zero),
    .opcode      (opcode),
    .car         (car_q),
    .sbr         (sbr_q)
);

// File: tb/useq_next_addr_tb.sv
module useq_next_addr_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cond_sel = '0;
    logic [1:0] br_kind = '0;
    logic [6:0] br_target = '0;
    logic       ind_bit = 1'b0;
    logic       acc_sign = 1'b0;
    logic       acc_is_zero = 1'b0;
    logic [3:0] opcode = '0;
    logic [6:0] car_o;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    logic [6:0] m_car;
    logic [6:0] m_sbr;

    always #10 clk = ~clk;

    useq_next_addr dut_i (
        .clk(clk), .rst(rst), .cond_sel(cond_sel), .br_kind(br_kind),
        .br_target(br_target), .ind_bit(ind_bit), .acc_sign(acc_sign),
        .acc_is_zero(acc_is_zero), .opcode(opcode), .car_o(car_o)
    );

    function automatic logic f_tested(input logic [1:0] cs, input logic d, input logic s, input logic z);
        case (cs)
            2'b00:   return 1'b1;
            2'b01:   return d;
            2'b10:   return s;
            default: return z;
        endcase
    endfunction

    task automatic check(input string req, input logic [6:0] exp_v);
        vectors++;
        if (car_o !== exp_v) begin
            miscompares++;
            $display("FAIL %s: car_o=%0d expected=%0d", req, car_o, exp_v);
        end
    endtask

    // drive one microinstruction, step one clock, compare against model
    task automatic step(input string req, input logic [1:0] cs, input logic [1:0] bk,
                        input logic [6:0] tgt, input logic d, input logic s,
                        input logic z, input logic [3:0] op);
        logic t;
        logic [6:0] inc;
        @(negedge clk);
        cond_sel = cs; br_kind = bk; br_target = tgt;
        ind_bit = d; acc_sign = s; acc_is_zero = z; opcode = op;
        t   = f_tested(cs, d, s, z);
        inc = m_car + 7'd1;
        case (bk)
            2'b00: m_car = t ? tgt : inc;
            2'b01: begin
                if (t) begin
                    m_sbr = inc;
                    m_car = tgt;
                end else begin
                    m_car = inc;
                end
            end
            2'b10: m_car = m_sbr;
            default: m_car = {1'b0, op, 2'b00};
        endcase
        @(posedge clk);
        #2;
        check(req, m_car);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: run hung, car_o=%0d expected=done", car_o);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        m_car = 7'd64;
        m_sbr = 7'd0;
        check("R1 reset address", 7'd64);
        @(negedge clk);
        rst = 1'b0;

        // R1: return straight after reset uses cleared return register
        step("R1 cleared return", 2'b11, 2'b10, 7'd5, 1'b0, 1'b0, 1'b0, 4'h0);

        // R2/R3: each condition source, true and false
        step("R3 jump U", 2'b00, 2'b00, 7'd20, 1'b0, 1'b0, 1'b0, 4'h0);
        step("R2 jump ind=1", 2'b01, 2'b00, 7'd40, 1'b1, 1'b0, 1'b0, 4'h0);
        step("R2 jump ind=0", 2'b01, 2'b00, 7'd90, 1'b0, 1'b1, 1'b1, 4'h0);
        step("R2 jump sign=1", 2'b10, 2'b00, 7'd33, 1'b0, 1'b1, 1'b0, 4'h0);
        step("R2 jump sign=0", 2'b10, 2'b00, 7'd77, 1'b1, 1'b0, 1'b1, 4'h0);
        step("R2 jump zero=1", 2'b11, 2'b00, 7'd100, 1'b0, 1'b0, 1'b1, 4'h0);
        step("R2 jump zero=0", 2'b11, 2'b00, 7'd10, 1'b1, 1'b1, 1'b0, 4'h0);

        // R4/R5: call taken then return, then a skipped call
        step("R4 call taken", 2'b00, 2'b01, 7'd70, 1'b0, 1'b0, 1'b0, 4'h0);
        step("R5 return after call", 2'b10, 2'b10, 7'd3, 1'b0, 1'b0, 1'b0, 4'h0);
        step("R4 call skipped", 2'b01, 2'b01, 7'd50, 1'b0, 1'b0, 1'b0, 4'h0);
        step("R4 sbr unchanged", 2'b00, 2'b10, 7'd50, 1'b0, 1'b0, 1'b0, 4'h0);

        // R8: nested call replaces return address
        step("R8 outer call", 2'b00, 2'b01, 7'd80, 1'b0, 1'b0, 1'b0, 4'h0);
        step("R8 inner call", 2'b00, 2'b01, 7'd95, 1'b0, 1'b0, 1'b0, 4'h0);
        step("R8 return to inner", 2'b00, 2'b10, 7'd0, 1'b0, 1'b0, 1'b0, 4'h0);

        // R7: wrap of step and of saved address
        step("R7 go 127", 2'b00, 2'b00, 7'd127, 1'b0, 1'b0, 1'b0, 4'h0);
        step("R7 step wraps", 2'b11, 2'b00, 7'd9, 1'b0, 1'b0, 1'b0, 4'h0);
        step("R7 go 127 again", 2'b00, 2'b00, 7'd127, 1'b0, 1'b0, 1'b0, 4'h0);
        step("R7 call at 127", 2'b00, 2'b01, 7'd12, 1'b0, 1'b0, 1'b0, 4'h0);
        step("R7 return to 0", 2'b01, 2'b10, 7'd12, 1'b0, 1'b0, 1'b0, 4'h0);

        // R6: every opcode, condition false where possible
        for (int op = 0; op < 16; op++) begin
            step("R6 dispatch", 2'(op % 4), 2'b11, 7'(op * 3), 1'b0, 1'b0, 1'b0, 4'(op));
        end

        // mixed random vectors
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step("R3 R4 R5 R6 random", r[1:0], r[3:2], r[10:4], r[11], r[12], r[13], r[17:14]);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule